// File: doc/BRIEF.md
# Memory-Card Command Line Engine

This block owns the single bidirectional command wire of a memory-card host. When a start request arrives, it forms a 48-bit command token from a 6-bit index and a 32-bit argument, protects the token with a CRC7, and shifts it out MSB first. It moves one bit per card-clock enable, which is a single-cycle strobe on the system clock. It then stops driving the wire, waits a fixed gap, and looks for the card's reply.

The reply is either a short 48-bit frame or a long 136-bit frame, chosen when the command starts. The engine captures the whole frame and checks its framing bits. It verifies the CRC7, except where the caller says the response type carries none. If no start bit arrives within a programmable number of card-clock samples, it gives up.

Completion is shown by a one-cycle pulse. Three sticky flags report a time-out, a CRC mismatch and a framing fault, and all three clear when the next command is accepted. The data lines run on a separate path, so a new command can be sent while the previous command's data is still moving.

Top module: `cmdl_engine`

## Requirements
- R1: After reset, `cmd_oe`, `busy`, `done`, `timeout`, `crc_err` and `frame_err` are 0.
- R2: An accepted command is sent MSB first, one bit per `tick`, as 48 bits: bit 47 = 0 (start), bit 46 = 1 (host direction), bits 45..40 = index, bits 39..8 = argument, bits 7..1 = CRC7 (x^7+x^3+1, zero seed) of bits 47..8, bit 0 = 1. For example, index 0 with argument 0 gives 0x400000000095.
- R3: `cmd_oe` is 1 only while the token is being sent, and it is 0 from the tick that moves out the final bit.
- R4: After a gap of 2 ticks, the first 0 sampled on `cmd_in` at a tick is the response start bit. From it, 48 bits (`rsp_long`=0) or 136 bits (`rsp_long`=1) are shifted into `rsp_frame`, with the last bit received at bit 0. A short frame leaves bits 135..48 at 0.
- R5: `done` pulses for exactly one cycle: in the cycle after the tick that samples the last response bit, or after the time-out tick. `busy` falls in that same cycle.
- R6: For a short response, `crc_err` is set when the CRC7 of frame bits 47..8 differs from frame bits 7..1.
- R7: For a long response, `crc_err` is set when the CRC7 of frame bits 127..8 differs from frame bits 7..1.
- R8: With `crc_skip`=1 latched at start, a CRC mismatch leaves `crc_err` at 0.
- R9: `frame_err` is set when the received end bit (frame bit 0) is 0, or when the direction bit (frame bit 46 for short, 134 for long) is 1.
- R10: After the gap, when `tmo_limit` consecutive samples are 1 (a limit of 0 acts as 1), `timeout` is set and capture ends.
- R11: `timeout`, `crc_err` and `frame_err` read 0 in the cycle after a command is accepted.
- R12: `start` is ignored while `busy` is 1: the token in flight is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Card-clock enable, one cycle wide |
| start | input | 1 | Command request, taken when idle |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_long | input | 1 | 1 = 136-bit response, 0 = 48-bit |
| crc_skip | input | 1 | 1 = do not check response CRC |
| tmo_limit | input | 16 | Response time-out in card-clock samples |
| cmd_in | input | 1 | Command wire as seen at the pad |
| cmd_out | output | 1 | Value driven onto the command wire |
| cmd_oe | output | 1 | Drive enable for the command wire |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Sticky: no response start in time |
| crc_err | output | 1 | Sticky: response CRC mismatch |
| frame_err | output | 1 | Sticky: response framing fault |
| rsp_frame | output | 136 | Captured response frame |

## Verification
The hardest case to reach from the ports is the time-out boundary. Here the response start bit lands on the last allowed sample or one sample later, and which one it is depends on the token length, the two-tick gap and the input synchroniser all together. The bench plays the card itself. It counts ticks from the one that moves the token's final bit out, drives the start bit a chosen number of ticks later, and drives every input half a cycle after a tick edge, so the synchroniser always settles before the next sample. One limit is then run twice: once with a delay that must be accepted, and once with a delay one tick longer that must time out. The other cases come from the same card model. It can corrupt a CRC bit or the end bit, and it can pulse start while a token is still going out.

// File: rtl/cmdl_pkg.sv
package cmdl_pkg;

   localparam int TOKEN_W  = 48;
   localparam int SHORT_W  = 48;
   localparam int LONG_W   = 136;
   localparam int CRC_W    = 7;
   localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TX,
      ST_GAP,
      ST_WAIT,
      ST_RX
   } cmdl_state_e;

   function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
      logic fb;
      logic [CRC_W-1:0] n;
      fb = b ^ c[CRC_W-1];
      n  = {c[CRC_W-2:0], 1'b0};
      if (fb) n = n ^ CRC_POLY;
      return n;
   endfunction

   function automatic logic [CRC_W-1:0] crc7_over40(input logic [39:0] d);
      logic [CRC_W-1:0] c;
      c = '0;
      for (int i = 39; i >= 0; i--) c = crc7_step(c, d[i]);
      return c;
   endfunction

endpackage

// File: rtl/cmdl_crc7.sv
module cmdl_crc7
   import cmdl_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             en,
   input  logic             din,
   output logic [CRC_W-1:0] crc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc <= '0;
      else if (clear) crc <= '0;
      else if (en)    crc <= crc7_step(crc, din);
   end
endmodule

// File: rtl/cmdl_timer.sv
module cmdl_timer #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             en,
   input  logic [TMO_W-1:0] limit,
   output logic             expire
);
   logic [TMO_W-1:0] cnt;
   logic [TMO_W:0]   nxt;

   assign nxt    = {1'b0, cnt} + {{TMO_W{1'b0}}, 1'b1};
   assign expire = en && (nxt >= {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clear) cnt <= '0;
      else if (en)    cnt <= nxt[TMO_W-1:0];
   end
endmodule

// File: rtl/cmdl_insync.sv
module cmdl_insync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_direct
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= '1;
            else begin
               ff[0] <= din;
               for (int i = 1; i < STAGES; i++) ff[i] <= ff[i-1];
            end
         end
         assign dout = ff[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cmdl_engine.sv
module cmdl_engine
   import cmdl_pkg::*;
#(
   parameter int TMO_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int GAP_TICKS   = 2,
   parameter int IDX_W       = 6,
   parameter int ARG_W       = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start,
   input  logic [IDX_W-1:0]  cmd_idx,
   input  logic [ARG_W-1:0]  cmd_arg,
   input  logic              rsp_long,
   input  logic              crc_skip,
   input  logic [TMO_W-1:0]  tmo_limit,
   input  logic              cmd_in,
   output logic              cmd_out,
   output logic              cmd_oe,
   output logic              busy,
   output logic              done,
   output logic              timeout,
   output logic              crc_err,
   output logic              frame_err,
   output logic [LONG_W-1:0] rsp_frame
);
   localparam int CNT_W      = $clog2(LONG_W);
   localparam int SHORT_LAST = SHORT_W - 1;
   localparam int LONG_LAST  = LONG_W - 1;
   localparam int LONG_CRC_HI = LONG_W - 8;   // exclusive top of long CRC window
   localparam int SHORT_CRC_N = SHORT_W - 8;  // bits covered in short frame

   generate
      if (IDX_W + ARG_W != TOKEN_W - 10) begin : g_bad_fields
         $error("index and argument widths must fill 38 token bits");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("SYNC_STAGES must be 0..3");
      end
      if (GAP_TICKS < 1 || GAP_TICKS > 64) begin : g_bad_gap
         $error("GAP_TICKS must be 1..64");
      end
      if (TMO_W < 2) begin : g_bad_tmo
         $error("TMO_W must be at least 2");
      end
   endgenerate

   cmdl_state_e         state;
   logic [TOKEN_W-1:0]  tx_sh;
   logic [CNT_W-1:0]    bcnt;
   logic                long_q, skip_q;
   logic [TMO_W-1:0]    tmo_q;
   logic [LONG_W-1:0]   rx_sh;
   logic [LONG_W-1:0]   rx_next;
   logic                line_s;
   logic [CRC_W-1:0]    crc_q;
   logic                crc_en, crc_clr;
   logic                tmr_en, tmr_clr, tmr_exp;
   logic [CNT_W-1:0]    last_pos;
   logic                dir_bit;
   logic [TOKEN_W-11:0] fields;

   cmdl_insync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(cmd_in), .dout(line_s)
   );

   assign crc_clr = (state == ST_WAIT);
   assign crc_en  = (state == ST_RX) && tick &&
                    (long_q ? (bcnt >= CNT_W'(8) && bcnt < CNT_W'(LONG_CRC_HI))
                            : (bcnt < CNT_W'(SHORT_CRC_N)));

   cmdl_crc7 u_crc (
      .clk(clk), .rst_n(rst_n), .clear(crc_clr), .en(crc_en), .din(line_s), .crc(crc_q)
   );

   assign tmr_clr = (state != ST_WAIT);
   assign tmr_en  = (state == ST_WAIT) && tick && line_s;

   cmdl_timer #(.TMO_W(TMO_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clear(tmr_clr), .en(tmr_en), .limit(tmo_q), .expire(tmr_exp)
   );

   assign fields   = {cmd_idx, cmd_arg};
   assign rx_next  = {rx_sh[LONG_W-2:0], line_s};
   assign last_pos = long_q ? CNT_W'(LONG_LAST) : CNT_W'(SHORT_LAST);
   assign dir_bit  = long_q ? rx_next[LONG_W-2] : rx_next[SHORT_W-2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         tx_sh     <= '1;
         bcnt      <= '0;
         long_q    <= 1'b0;
         skip_q    <= 1'b0;
         tmo_q     <= '0;
         rx_sh     <= '0;
         done      <= 1'b0;
         timeout   <= 1'b0;
         crc_err   <= 1'b0;
         frame_err <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: if (start) begin
               tx_sh     <= {2'b01, fields, crc7_over40({2'b01, fields}), 1'b1};
               bcnt      <= CNT_W'(TOKEN_W - 1);
               long_q    <= rsp_long;
               skip_q    <= crc_skip;
               tmo_q     <= tmo_limit;
               timeout   <= 1'b0;
               crc_err   <= 1'b0;
               frame_err <= 1'b0;
               state     <= ST_TX;
            end
            ST_TX: if (tick) begin
               if (bcnt == '0) begin
                  bcnt  <= CNT_W'(GAP_TICKS - 1);
                  state <= ST_GAP;
               end else begin
                  tx_sh <= {tx_sh[TOKEN_W-2:0], 1'b1};
                  bcnt  <= bcnt - 1'b1;
               end
            end
            ST_GAP: if (tick) begin
               if (bcnt == '0) state <= ST_WAIT;
               else            bcnt  <= bcnt - 1'b1;
            end
            ST_WAIT: if (tick) begin
               if (!line_s) begin
                  rx_sh <= '0;
                  bcnt  <= CNT_W'(1);
                  state <= ST_RX;
               end else if (tmr_exp) begin
                  timeout <= 1'b1;
                  done    <= 1'b1;
                  state   <= ST_IDLE;
               end
            end
            ST_RX: if (tick) begin
               rx_sh <= rx_next;
               if (bcnt == last_pos) begin
                  done      <= 1'b1;
                  frame_err <= dir_bit || !line_s;
                  crc_err   <= !skip_q && (crc_q != rx_next[CRC_W:1]);
                  state     <= ST_IDLE;
               end else begin
                  bcnt <= bcnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cmd_oe    = (state == ST_TX);
   assign cmd_out   = cmd_oe ? tx_sh[TOKEN_W-1] : 1'b1;
   assign busy      = (state != ST_IDLE);
   assign rsp_frame = rx_sh;

endmodule

// File: rtl/cmdl_engine_chk.sv
module cmdl_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic cmd_oe,
   input logic busy,
   input logic done,
   input logic timeout,
   input logic crc_err,
   input logic frame_err
);
   a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r5_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (busy || done));

   a_r5_fall_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   a_r3_no_drive_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !cmd_oe);

   a_r11_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (!timeout && !crc_err && !frame_err));

   a_r10_timeout_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout) |-> done);

   a_r6_crc_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(crc_err) |-> done);

   a_r9_frame_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_err) |-> done);

   a_r12_flags_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(timeout) || done));
endmodule

bind cmdl_engine cmdl_engine_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .cmd_oe(cmd_oe), .busy(busy),
   .done(done), .timeout(timeout), .crc_err(crc_err), .frame_err(frame_err)
);

// File: tb/cmdl_engine_tb.sv
`timescale 1ns/1ps
module cmdl_engine_tb_top;
   logic         clk = 0;
   logic         rst_n = 0;
   logic         tick;
   logic [1:0]   tdiv;
   logic         start = 0;
   logic [5:0]   cmd_idx = 0;
   logic [31:0]  cmd_arg = 0;
   logic         rsp_long = 0;
   logic         crc_skip = 0;
   logic [15:0]  tmo_limit = 16'd8;
   logic         cmd_in = 1;
   logic         cmd_out, cmd_oe, busy, done, timeout, crc_err, frame_err;
   logic [135:0] rsp_frame;
   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) begin tdiv <= 0; tick <= 0; end
      else begin tdiv <= tdiv + 1; tick <= (tdiv == 2'd2); end
   end

   cmdl_engine dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .cmd_idx(cmd_idx),
      .cmd_arg(cmd_arg), .rsp_long(rsp_long), .crc_skip(crc_skip), .tmo_limit(tmo_limit),
      .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy), .done(done),
      .timeout(timeout), .crc_err(crc_err), .frame_err(frame_err), .rsp_frame(rsp_frame)
   );

   task automatic check(input string req, input logic [135:0] act, input logic [135:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [6:0] crc_ref(input logic [135:0] v, input int hi, input int lo);
      logic [6:0] c = 0;
      logic fb;
      for (int i = hi; i >= lo; i--) begin
         fb = v[i] ^ c[6];
         c = {c[5:0], 1'b0};
         if (fb) c = c ^ 7'h09;
      end
      return c;
   endfunction

   function automatic logic [47:0] token_ref(input logic [5:0] idx, input logic [31:0] arg);
      logic [135:0] t = {88'b0, 2'b01, idx, arg, 8'h00};
      return {2'b01, idx, arg, crc_ref(t, 47, 8), 1'b1};
   endfunction

   function automatic logic [135:0] short_rsp(input logic [5:0] idx, input logic [31:0] arg);
      logic [135:0] f = {88'b0, 2'b00, idx, arg, 8'h01};
      f[7:1] = crc_ref(f, 47, 8);
      return f;
   endfunction

   function automatic logic [135:0] long_rsp(input logic [119:0] body);
      logic [135:0] f = {2'b00, 6'h3F, body, 8'h01};
      f[7:1] = crc_ref(f, 127, 8);
      return f;
   endfunction

   task automatic wait_tick();
      while (!tick) @(negedge clk);
   endtask

   task automatic pass_tick();
      wait_tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic lng,
                        input logic skip, input logic [15:0] lim);
      cmd_idx = idx; cmd_arg = arg; rsp_long = lng; crc_skip = skip; tmo_limit = lim;
      start = 1;
      @(posedge clk);
      @(negedge clk);
      start = 0;
      check("R11 flags cleared on accept", {133'b0, timeout, crc_err, frame_err}, 136'b0);
   endtask

   task automatic capture_token(input logic [47:0] exp, input bit poke);
      logic [47:0] tok = 0;
      int oe_bad = 0;
      for (int i = 0; i < 48; i++) begin
         wait_tick();
         tok = {tok[46:0], cmd_out};
         if (!cmd_oe) oe_bad++;
         if (poke && i == 10) begin
            start = 1; cmd_idx = 6'h2A; cmd_arg = 32'hFFFF0000;
         end
         @(posedge clk);
         @(negedge clk);
         start = 0;
      end
      check(poke ? "R12 token unchanged by start while busy" : "R2 token bits", {88'b0, tok}, {88'b0, exp});
      check("R3 driven through token", oe_bad, 0);
      check("R3 released after end bit", {135'b0, cmd_oe}, 136'b0);
   endtask

   task automatic card_reply(input logic [135:0] f, input int n, input int dly);
      for (int j = 1; j < dly; j++) pass_tick();
      wait_tick(); @(posedge clk); @(negedge clk);
      for (int i = n - 1; i >= 0; i--) begin
         cmd_in = f[i];
         if (i != 0) pass_tick();
      end
      wait_tick(); @(posedge clk); @(negedge clk);
      cmd_in = 1;
   endtask

   task automatic run_cmd(input string tag, input logic [5:0] idx, input logic [31:0] arg,
                          input logic lng, input logic skip, input logic [15:0] lim,
                          input logic [135:0] f, input logic [135:0] flip, input int dly,
                          input logic e_crc, input logic e_frm, input bit poke);
      logic [135:0] sent = f ^ flip;
      int n = lng ? 136 : 48;
      issue(idx, arg, lng, skip, lim);
      capture_token(token_ref(idx, arg), poke);
      card_reply(sent, n, dly);
      check({tag, " R5 done at last bit"}, {134'b0, done, busy}, {134'b0, 2'b10});
      check({tag, " R4 captured frame"}, rsp_frame, lng ? sent : {88'b0, sent[47:0]});
      check({tag, " R6 R7 R8 crc flag"}, {135'b0, crc_err}, {135'b0, e_crc});
      check({tag, " R9 frame flag"}, {135'b0, frame_err}, {135'b0, e_frm});
      check({tag, " R10 no timeout"}, {135'b0, timeout}, 136'b0);
      @(negedge clk);
      check({tag, " R5 done one cycle"}, {135'b0, done}, 136'b0);
   endtask

   task automatic t_reset();
      check("R1 reset outputs", {130'b0, cmd_oe, busy, done, timeout, crc_err, frame_err}, 136'b0);
   endtask

   task automatic t_anchor();
      check("R2 reference token index0", {88'b0, token_ref(6'd0, 32'd0)}, {88'b0, 48'h400000000095});
   endtask

   task automatic t_timeout(input logic [15:0] lim);
      issue(6'd13, 32'h0000BEEF, 1'b0, 1'b0, lim);
      capture_token(token_ref(6'd13, 32'h0000BEEF), 0);
      for (int j = 0; j < lim + 2; j++) pass_tick();
      check("R10 timeout at limit", {133'b0, done, timeout, busy}, {133'b0, 3'b110});
      check("R10 no false errors", {134'b0, crc_err, frame_err}, 136'b0);
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1;
      repeat (3) @(negedge clk);
      t_reset();
      t_anchor();
      run_cmd("short_ok", 6'd17, 32'h00001000, 0, 0, 16'd8,
              short_rsp(6'd17, 32'h00000900), 136'b0, 3, 0, 0, 0);
      run_cmd("short_alt", 6'd55, 32'hA5A5_5A5A, 0, 0, 16'd8,
              short_rsp(6'd55, 32'h12345678), 136'b0, 2, 0, 0, 0);
      run_cmd("long_ok", 6'd2, 32'h0, 1, 0, 16'd8,
              long_rsp({32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 24'h5A5A5A}), 136'b0, 4, 0, 0, 0);
      run_cmd("long_badcrc", 6'd9, 32'h00010000, 1, 0, 16'd8,
              long_rsp({120{1'b1}} ^ 120'h1), 136'h2, 2, 1, 0, 0);
      run_cmd("short_badcrc", 6'd24, 32'h00000200, 0, 0, 16'd8,
              short_rsp(6'd24, 32'h00000900), 136'h8, 2, 1, 0, 0);
      run_cmd("skip_crc", 6'd41, 32'h40FF8000, 0, 1, 16'd8,
              short_rsp(6'h3F, 32'h80FF8000), 136'h10, 2, 0, 0, 0);
      run_cmd("bad_end", 6'd7, 32'h12340000, 0, 0, 16'd8,
              short_rsp(6'd7, 32'h00000700), 136'h1, 2, 0, 1, 0);
      run_cmd("bad_dir", 6'd7, 32'h12340000, 0, 1, 16'd8,
              short_rsp(6'd7, 32'h00000700), 136'h4000_0000_0000, 2, 0, 1, 0);
      run_cmd("edge_ok", 6'd3, 32'h0, 0, 0, 16'd4,
              short_rsp(6'd3, 32'hAAAA0000), 136'b0, 5, 0, 0, 0);
      t_timeout(16'd4);
      run_cmd("busy_start", 6'd16, 32'h00000200, 0, 0, 16'd8,
              short_rsp(6'd16, 32'h00000900), 136'b0, 2, 0, 0, 1);
      t_timeout(16'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule